// File: doc/BRIEF.md
# Sleep-State Power Mode Sequencer

This block is the mode controller of a memory power subsystem. It picks one of three modes, off, run and suspend, from a sleep request, three supply-good flags, a reference-good flag, a thermal trip flag and a latched overcurrent flag. It drives the enables of the main switching regulator, the termination regulator and the core regulator. It also drives a standby select for the main regulator and the hold controls that park the termination output in high impedance and pull the core driver low.

Start-up is ordered. The standby supply monitor wakes once the reference is good. The two auxiliary supply monitors wake only once the standby supply is good. The main regulator starts first. The termination and core regulators follow only after the main regulator reports that its soft-start is done and its output is in regulation. Every flag crosses a two-flop synchroniser before the mode logic sees it. Analog monitors, the regulators themselves and temperature sensing sit outside this block and reach it as digital flags.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset, mode_o is 2'b00 (off), every regulator enable, the standby select and both monitor enables are 0, and term_hiz_o and core_low_o are 1.
- R2: mon_stby_en_o is 1 only while ref_ok_i is high. mon_aux_en_o is 1 only while both ref_ok_i and stby_ok_i are high. Auxiliary supply-good flags count only while mon_aux_en_o is 1.
- R3: From off (2'b00), the block enters run (2'b01) when sleep_req_i is low and both aux12_ok_i and aux5_ok_i are high.
- R4: From run, sleep_req_i high moves the block to suspend (2'b10). Off never moves directly to suspend, even with sleep_req_i high and all supplies good.
- R5: From run, with sleep_req_i low, loss of either auxiliary supply-good flag moves the block to off.
- R6: In suspend, loss of auxiliary supply-good flags leaves the mode unchanged. Suspend returns to run only when sleep_req_i is low and both auxiliary flags are high, and it never moves to off except through R9.
- R7: main_en_o is 1 in run and in suspend. main_stby_o is 1 only in suspend.
- R8: term_en_o and core_en_o are 1 only in run, and only after main_inreg_i has been seen high during the current visit to run. They then stay on until run is left. term_hiz_o and core_low_o are 1 whenever the matching enable is 0.
- R9: A thermal trip, or loss of ref_ok_i or stby_ok_i, forces off from any mode. Once the cause clears, start-up follows R3 again.
- R10: While ocp_latch_i is high, all regulator enables are 0 and the mode is unchanged. The enables return when the latch clears.
- R11: A change on any input flag reaches the mode on the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_ok_i | input | 1 | Reference in regulation |
| stby_ok_i | input | 1 | Standby supply good |
| aux12_ok_i | input | 1 | High auxiliary supply good |
| aux5_ok_i | input | 1 | Low auxiliary supply good |
| sleep_req_i | input | 1 | Sleep request, high asks for suspend |
| therm_trip_i | input | 1 | Over-temperature flag |
| ocp_latch_i | input | 1 | Latched overcurrent flag |
| main_inreg_i | input | 1 | Main regulator soft-start done and in regulation |
| mode_o | output | 2 | Mode: 00 off, 01 run, 10 suspend |
| mon_stby_en_o | output | 1 | Standby supply monitor enable |
| mon_aux_en_o | output | 1 | Auxiliary supply monitors enable |
| main_en_o | output | 1 | Main switching regulator enable |
| main_stby_o | output | 1 | Main regulator standby (doubled frequency) select |
| term_en_o | output | 1 | Termination regulator enable |
| core_en_o | output | 1 | Core regulators enable |
| term_hiz_o | output | 1 | Termination output held in high impedance |
| core_low_o | output | 1 | Core gate drivers held low |

## Verification
The hardest case to reach from the ports is suspend with the auxiliary supplies gone and sleep already released, because this is the only place where the ignored-loss rule and the forbidden suspend-to-off link meet. The bench enters run and then suspend, drops one auxiliary flag, and then releases sleep_req_i. It checks that the mode stays in suspend until the flag returns. A second hard case is a thermal trip that arrives while the block is in suspend. The bench drives the trip after a full run-to-suspend sequence, to show that the hard stop is the only way out of suspend to off.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
   typedef enum logic [1:0] {
      MODE_OFF  = 2'b00,
      MODE_RUN  = 2'b01,
      MODE_SUSP = 2'b10
   } mode_t;

   localparam int unsigned FLAG_COUNT = 8;
   localparam int unsigned F_REF   = 0;
   localparam int unsigned F_STBY  = 1;
   localparam int unsigned F_AUX12 = 2;
   localparam int unsigned F_AUX5  = 3;
   localparam int unsigned F_SLEEP = 4;
   localparam int unsigned F_THERM = 5;
   localparam int unsigned F_OCP   = 6;
   localparam int unsigned F_INREG = 7;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("pwrseq_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pwrseq_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= '0;
      else        stg_q[0] <= async_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[s] <= '0;
         else        stg_q[s] <= stg_q[s-1];
      end
   end

   assign sync_o = stg_q[LAST];
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
   import pwrseq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  hard_stop,
   input  logic  sleep,
   input  logic  aux_ok,
   input  logic  inreg,
   output mode_t mode,
   output logic  ds_armed
);
   mode_t mode_q, mode_d;
   logic  armed_q, armed_d;

   always_comb begin
      mode_d = mode_q;
      if (hard_stop) begin
         mode_d = MODE_OFF;
      end else begin
         unique case (mode_q)
            MODE_OFF:  if (!sleep && aux_ok) mode_d = MODE_RUN;
            MODE_RUN:  if (sleep)            mode_d = MODE_SUSP;
                       else if (!aux_ok)     mode_d = MODE_OFF;
            MODE_SUSP: if (!sleep && aux_ok) mode_d = MODE_RUN;
            default:                         mode_d = MODE_OFF;
         endcase
      end
   end

   always_comb begin
      armed_d = armed_q;
      if (mode_q != MODE_RUN || mode_d != MODE_RUN) armed_d = 1'b0;
      else if (inreg)                               armed_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_OFF;
         armed_q <= 1'b0;
      end else begin
         mode_q  <= mode_d;
         armed_q <= armed_d;
      end
   end

   assign mode     = mode_q;
   assign ds_armed = armed_q;
endmodule

// File: rtl/pwrseq_outmap.sv
module pwrseq_outmap
   import pwrseq_pkg::*;
#(
   parameter int unsigned DS_COUNT = 2
) (
   input  mode_t               mode,
   input  logic                ds_armed,
   input  logic                ocp,
   output logic                main_en,
   output logic                main_stby,
   output logic [DS_COUNT-1:0] ds_en,
   output logic [DS_COUNT-1:0] ds_hold
);
   if (DS_COUNT < 1) begin : g_bad_count
      $error("pwrseq_outmap: DS_COUNT must be at least 1");
   end

   logic ds_go;

   assign main_en   = (mode == MODE_RUN || mode == MODE_SUSP) && !ocp;
   assign main_stby = (mode == MODE_SUSP);
   assign ds_go     = (mode == MODE_RUN) && ds_armed && !ocp;

   for (genvar i = 0; i < DS_COUNT; i++) begin : g_ds
      assign ds_en[i]   = ds_go;
      assign ds_hold[i] = !ds_go;
   end
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
   import pwrseq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_ok_i,
   input  logic       stby_ok_i,
   input  logic       aux12_ok_i,
   input  logic       aux5_ok_i,
   input  logic       sleep_req_i,
   input  logic       therm_trip_i,
   input  logic       ocp_latch_i,
   input  logic       main_inreg_i,
   output logic [1:0] mode_o,
   output logic       mon_stby_en_o,
   output logic       mon_aux_en_o,
   output logic       main_en_o,
   output logic       main_stby_o,
   output logic       term_en_o,
   output logic       core_en_o,
   output logic       term_hiz_o,
   output logic       core_low_o
);
   localparam int unsigned DS_COUNT = 2;

   logic [FLAG_COUNT-1:0] flags_raw, flags_s;
   logic ref_s, stby_s, aux_ok_s, sleep_s, ocp_s, hard_stop_s;
   logic ds_armed;
   logic [DS_COUNT-1:0] ds_en, ds_hold;
   mode_t mode;

   always_comb begin
      flags_raw          = '0;
      flags_raw[F_REF]   = ref_ok_i;
      flags_raw[F_STBY]  = stby_ok_i;
      flags_raw[F_AUX12] = aux12_ok_i;
      flags_raw[F_AUX5]  = aux5_ok_i;
      flags_raw[F_SLEEP] = sleep_req_i;
      flags_raw[F_THERM] = therm_trip_i;
      flags_raw[F_OCP]   = ocp_latch_i;
      flags_raw[F_INREG] = main_inreg_i;
   end

   pwrseq_sync #(.WIDTH(FLAG_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (flags_raw),
      .sync_o  (flags_s)
   );

   assign ref_s       = flags_s[F_REF];
   assign stby_s      = ref_s && flags_s[F_STBY];
   assign aux_ok_s    = stby_s && flags_s[F_AUX12] && flags_s[F_AUX5];
   assign sleep_s     = flags_s[F_SLEEP];
   assign ocp_s       = flags_s[F_OCP];
   assign hard_stop_s = !stby_s || flags_s[F_THERM];

   pwrseq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .hard_stop (hard_stop_s),
      .sleep     (sleep_s),
      .aux_ok    (aux_ok_s),
      .inreg     (flags_s[F_INREG]),
      .mode      (mode),
      .ds_armed  (ds_armed)
   );

   pwrseq_outmap #(.DS_COUNT(DS_COUNT)) u_map (
      .mode      (mode),
      .ds_armed  (ds_armed),
      .ocp       (ocp_s),
      .main_en   (main_en_o),
      .main_stby (main_stby_o),
      .ds_en     (ds_en),
      .ds_hold   (ds_hold)
   );

   assign mode_o        = mode;
   assign mon_stby_en_o = ref_s;
   assign mon_aux_en_o  = stby_s;
   assign term_en_o     = ds_en[0];
   assign core_en_o     = ds_en[1];
   assign term_hiz_o    = ds_hold[0];
   assign core_low_o    = ds_hold[1];
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode,
   input logic       hard_stop,
   input logic       sleep,
   input logic       ocp,
   input logic       main_en,
   input logic       main_stby,
   input logic       term_en,
   input logic       core_en,
   input logic       term_hiz,
   input logic       core_low
);
   // R4
   off_not_to_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'b00 |=> mode != 2'b10);
   // R6
   susp_not_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && !hard_stop) |=> mode != 2'b00);
   // R6
   susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && !hard_stop && sleep) |=> mode == 2'b10);
   // R7
   susp_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'b10 |-> (main_stby && term_hiz && core_low));
   // R8
   ds_only_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (term_en || core_en) |-> mode == 2'b01);
   // R9
   hard_stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hard_stop |=> mode == 2'b00);
   // R10
   ocp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ocp |-> !(main_en || term_en || core_en));
   // R10
   ocp_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ocp && !hard_stop && mode == 2'b10) |=> $stable(mode) || !sleep);
endmodule

bind pwrseq_ctrl pwrseq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode_o),
   .hard_stop (hard_stop_s),
   .sleep     (sleep_s),
   .ocp       (ocp_s),
   .main_en   (main_en_o),
   .main_stby (main_stby_o),
   .term_en   (term_en_o),
   .core_en   (core_en_o),
   .term_hiz  (term_hiz_o),
   .core_low  (core_low_o)
);

// File: tb/pwrseq_ctrl_bench.sv
module pwrseq_ctrl_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [1:0] OFF = 2'b00, RUN = 2'b01, SUSP = 2'b10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ref_ok = 0, stby_ok = 0, aux12 = 0, aux5 = 0, sleep = 0;
   logic therm = 0, ocp = 0, inreg = 0;
   logic [1:0] mode;
   logic mon_stby, mon_aux, main_en, main_stby, term_en, core_en, term_hiz, core_low;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwrseq_ctrl u_pwrseq_ctrl (
      .clk(clk), .rst_n(rst_n), .ref_ok_i(ref_ok), .stby_ok_i(stby_ok),
      .aux12_ok_i(aux12), .aux5_ok_i(aux5), .sleep_req_i(sleep),
      .therm_trip_i(therm), .ocp_latch_i(ocp), .main_inreg_i(inreg),
      .mode_o(mode), .mon_stby_en_o(mon_stby), .mon_aux_en_o(mon_aux),
      .main_en_o(main_en), .main_stby_o(main_stby), .term_en_o(term_en),
      .core_en_o(core_en), .term_hiz_o(term_hiz), .core_low_o(core_low)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // outputs packed: main_en,main_stby,term_en,core_en,term_hiz,core_low
   function automatic int outs();
      return {main_en, main_stby, term_en, core_en, term_hiz, core_low};
   endfunction

   task automatic t_reset;
      check("R1 mode", mode, OFF);
      check("R1 outputs", outs(), 6'b000011);
      check("R1 monitors", {mon_stby, mon_aux}, 0);
   endtask

   task automatic t_monitors;
      aux12 = 1; aux5 = 1; sleep = 0;
      ref_ok = 1; tick(4);
      check("R2 stby mon on", mon_stby, 1);
      check("R2 aux mon off", mon_aux, 0);
      check("R2 aux ignored while mon off", mode, OFF);
      stby_ok = 1; tick(4);
      check("R2 aux mon on", mon_aux, 1);
   endtask

   task automatic t_startup;
      // mode already in run after t_monitors
      check("R3 off to run", mode, RUN);
      check("R7 run outputs", outs(), 6'b100011);
      inreg = 1; tick(4);
      check("R8 ds on after inreg", outs(), 6'b101100);
      inreg = 0; tick(4);
      check("R8 ds held", {term_en, core_en}, 2'b11);
      sleep = 1; tick(2);
      check("R11 not before third edge", mode, RUN);
      tick(1);
      check("R11 third edge R4 run to susp", mode, SUSP);
   endtask

   task automatic t_suspend;
      check("R7 susp outputs", outs(), 6'b110011);
      aux12 = 0; tick(4);
      check("R6 aux loss ignored", mode, SUSP);
      sleep = 0; tick(4);
      check("R6 susp not to off", mode, SUSP);
      aux12 = 1; tick(4);
      check("R6 susp to run", mode, RUN);
      check("R8 rearm needed", {term_en, term_hiz, core_low}, 3'b011);
      inreg = 1; tick(4);
      check("R8 rearmed", {term_en, core_en}, 2'b11);
   endtask

   task automatic t_dropout;
      aux5 = 0; tick(4);
      check("R5 run to off", mode, OFF);
      check("R5 off outputs", outs(), 6'b000011);
      sleep = 1; aux5 = 1; tick(6);
      check("R4 off not to susp", mode, OFF);
      sleep = 0; tick(4);
      check("R3 restart", mode, RUN);
   endtask

   task automatic t_thermal;
      sleep = 1; tick(4);
      check("R9 setup susp", mode, SUSP);
      therm = 1; tick(4);
      check("R9 thermal from susp", mode, OFF);
      therm = 0; tick(4);
      check("R9 stays off with sleep", mode, OFF);
      sleep = 0; tick(4);
      check("R9 resume", mode, RUN);
      stby_ok = 0; tick(4);
      check("R9 standby loss", mode, OFF);
      check("R2 aux mon drops", mon_aux, 0);
      stby_ok = 1; tick(4);
      check("R9 standby back", mode, RUN);
   endtask

   task automatic t_ocp;
      tick(2);
      check("R10 pre ds", {term_en, core_en}, 2'b11);
      ocp = 1; tick(4);
      check("R10 all off", {main_en, term_en, core_en}, 0);
      check("R10 mode kept", mode, RUN);
      ocp = 0; tick(4);
      check("R10 back", {main_en, term_en, core_en}, 3'b111);
   endtask

   initial begin
      tick(3);
      rst_n = 1; tick(1);
      t_reset();
      t_monitors();
      t_startup();
      t_suspend();
      t_dropout();
      t_thermal();
      t_ocp();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule